// File: doc/BRIEF.md
# Ethernet Receive Slot Ring

This block takes received Ethernet frames as an 8-bit byte stream with valid and last-byte strobes, and stores each frame in one of a small ring of fixed-size slots held in on-chip memory. There is no back-pressure: every byte presented with `s_valid` high is taken. The block decides per frame whether to keep it. A frame is kept when its destination address is the programmed station address or broadcast, or when promiscuous mode is on. It records the byte count of each kept frame and its overflow flag.

The address verdict is known only once the first eight bytes have gone by. These are the six destination bytes plus a two-byte filter pipeline. So every frame starts writing into the slot just after the committed write pointer, which is the slot it will own if kept. The pointer moves onto that slot when the verdict is positive. A rejected frame stops writing there and leaves the pointer alone, and the next frame reuses that slot. A kept frame is published to the host only after its last byte has been stored. The host sees the oldest published frame through a combinational byte read port with its length and overflow flag. A one-cycle `pop` strobe releases that frame. `avail` is high whenever at least one published frame is unread.

Top module: `eth_rx_slot_ring`

## Requirements
- R1: After reset `avail` is 0, and `rd_len` and `rd_trunc` are 0.
- R2: A frame is kept when its first six bytes equal `station_mac` sent most significant byte first (byte 0 is `station_mac[47:40]`). Byte k of the frame then reads back at `rd_addr` = k.
- R3: A frame whose six destination bytes are all 8'hFF is kept regardless of `station_mac`.
- R4: A frame that fails the address check is discarded. `avail` does not change, the following frame lands in the same slot, and frames already stored and unread read back unchanged.
- R5: While `promisc` is 1 (sampled on byte 5), every frame of at least eight bytes is kept, whatever its destination.
- R6: The verdict is formed anew for every frame. A mismatching frame that follows a kept frame is discarded.
- R7: `rd_len` counts every byte of the frame, FCS included. `avail` and `rd_len` stay unchanged until the last byte is taken, and they show the new frame in the cycle after the edge that takes the last byte.
- R8: `s_last` and `s_data` are ignored while `s_valid` is 0, so idle cycles inside or after a frame change no stored length or data.
- R9: The first frame after reset is captured like any other.
- R10: The ring holds at most SLOTS-1 unread frames. A frame that starts while the ring is full is dropped whole, and the stored frames stay intact and in order.
- R11: A frame longer than SLOT_BYTES keeps its first SLOT_BYTES bytes. It reports `rd_len` = SLOT_BYTES and `rd_trunc` = 1. A frame of exactly SLOT_BYTES reports `rd_trunc` = 0.
- R12: Frames are read out oldest first, and `pop` advances to the next one. A `pop` while `avail` is 0 has no effect.
- R13: A frame ending before its eighth byte (the verdict point) is discarded even if its address matches. An eight-byte matching frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte strobe for the incoming stream |
| s_data | input | 8 | Incoming frame byte |
| s_last | input | 1 | Marks the final byte of a frame when `s_valid` is 1 |
| station_mac | input | 48 | Own station address, first wire byte in bits 47:40 |
| promisc | input | 1 | Keep every frame regardless of destination |
| rd_addr | input | $clog2(SLOT_BYTES) | Byte offset within the oldest unread frame |
| rd_data | output | 8 | Byte at `rd_addr` of the oldest unread frame |
| rd_len | output | $clog2(SLOT_BYTES+1) | Stored byte count of the oldest unread frame |
| rd_trunc | output | 1 | Oldest unread frame overflowed its slot |
| pop | input | 1 | Release the oldest unread frame |
| avail | output | 1 | At least one complete frame is waiting |

## Verification
The bench targets the hazards of the speculative slot. One case is a rejected frame sitting between two kept ones: a design that let the rejected body follow the committed pointer would corrupt the older unread frame. Another is a mismatching frame right after a kept frame: a verdict carried over from the previous frame would publish it. The bench watches `avail` and `rd_len` on the cycle before the last byte, where a design that publishes at the verdict point would show the new frame early. It also sweeps frame lengths across the runt, verdict and slot-overflow boundaries, with idle gaps that hold `s_last` high, and fills the ring past capacity. These catch off-by-one overflow flags, a length rewritten by an idle cycle, and a full ring that overwrites its oldest frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   localparam int unsigned ADDR_OCTETS = 6;
   localparam logic [7:0]  BCAST_OCTET = 8'hFF;

   // Byte k of a station address in wire order, first byte in bits 47:40.
   function automatic logic [7:0] mac_octet(input logic [47:0] mac, input logic [2:0] k);
      logic [7:0] v;
      case (k)
         3'd0:    v = mac[47:40];
         3'd1:    v = mac[39:32];
         3'd2:    v = mac[31:24];
         3'd3:    v = mac[23:16];
         3'd4:    v = mac[15:8];
         3'd5:    v = mac[7:0];
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter
   import rxr_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   input  logic [47:0]      station,
   input  logic             promisc,
   output logic             verdict
);

   localparam logic [IDX_W-1:0] LAST_OCT = IDX_W'(ADDR_OCTETS - 1);

   logic uc_q, bc_q, verdict_q;
   logic hit_uc, hit_bc, in_addr;

   assign in_addr = idx <= LAST_OCT;
   assign hit_uc  = data == mac_octet(station, idx[2:0]);
   assign hit_bc  = data == BCAST_OCTET;

   // Per-frame accumulation: byte 0 reloads the flags, so no verdict
   // survives from one frame into the next.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uc_q      <= 1'b1;
         bc_q      <= 1'b1;
         verdict_q <= 1'b0;
      end else if (beat && in_addr) begin
         if (idx == '0) begin
            uc_q <= hit_uc;
            bc_q <= hit_bc;
         end else begin
            uc_q <= uc_q & hit_uc;
            bc_q <= bc_q & hit_bc;
         end
         if (idx == LAST_OCT)
            verdict_q <= promisc | (uc_q & hit_uc) | (bc_q & hit_bc);
      end
   end

   assign verdict = verdict_q;

   a_r5_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && idx == LAST_OCT && promisc) |=> verdict);

   a_r3_bcast_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && idx == LAST_OCT && bc_q && data == BCAST_OCTET) |=> verdict);

endmodule

// File: rtl/rxr_ring_ctl.sv
module rxr_ring_ctl #(
   parameter int SLOTS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sof,
   input  logic                     commit,
   input  logic                     publish,
   input  logic                     pop,
   output logic [$clog2(SLOTS)-1:0] wslot,
   output logic                     drop,
   output logic [$clog2(SLOTS)-1:0] pub_slot,
   output logic [$clog2(SLOTS)-1:0] first_slot
);

   localparam int SLOT_W = $clog2(SLOTS);

   logic [SLOT_W-1:0] wr_q, pub_q, first_q, fslot_q, nxt;
   logic              drop_q, full, has_frame;

   assign nxt       = wr_q + 1'b1;
   assign full      = nxt == first_q;
   assign wslot     = sof ? nxt  : fslot_q;
   assign drop      = sof ? full : drop_q;
   assign has_frame = pub_q != first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= '0;
         pub_q   <= '0;
         first_q <= '0;
         fslot_q <= SLOT_W'(1);
         drop_q  <= 1'b0;
      end else begin
         if (sof) begin
            fslot_q <= nxt;
            drop_q  <= full;
         end
         if (commit)
            wr_q <= wslot;
         if (publish)
            pub_q <= wslot;
         if (pop && has_frame)
            first_q <= first_q + 1'b1;
      end
   end

   assign pub_slot   = pub_q;
   assign first_slot = first_q;

   a_r12_idle_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !has_frame) |=> $stable(first_q));

   a_r10_room_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q != $past(wr_q)) |-> ($past(wr_q) + 1'b1 != $past(first_q)));

   a_r7_publish_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (pub_q != $past(pub_q)) |-> $past(publish));

   a_r4_commit_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q != $past(wr_q)) |-> (wr_q == $past(wr_q) + 1'b1));

endmodule

// File: rtl/rxr_byte_store.sv
module rxr_byte_store #(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [$clog2(SLOTS)-1:0]          wslot,
   input  logic [$clog2(SLOT_BYTES)-1:0]     widx,
   input  logic [7:0]                        wdata,
   input  logic                              len_we,
   input  logic [$clog2(SLOT_BYTES+1)-1:0]   len_val,
   input  logic                              trunc_val,
   input  logic [$clog2(SLOTS)-1:0]          rslot,
   input  logic [$clog2(SLOT_BYTES)-1:0]     raddr,
   output logic [7:0]                        rdata,
   output logic [$clog2(SLOT_BYTES+1)-1:0]   rlen,
   output logic                              rtrunc
);

   localparam int SLOT_W = $clog2(SLOTS);
   localparam int BYTE_W = $clog2(SLOT_BYTES);
   localparam int LEN_W  = $clog2(SLOT_BYTES + 1);
   localparam int DEPTH  = SLOTS * SLOT_BYTES;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[{wslot, widx}] <= wdata;
   end

   assign rdata = mem[{rslot, raddr}];

   logic [LEN_W-1:0] len_vec [SLOTS];
   logic             trn_vec [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [LEN_W-1:0] len_r;
      logic             trn_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            len_r <= '0;
            trn_r <= 1'b0;
         end else if (len_we && wslot == SLOT_W'(s)) begin
            len_r <= len_val;
            trn_r <= trunc_val;
         end
      end
      assign len_vec[s] = len_r;
      assign trn_vec[s] = trn_r;
   end

   assign rlen   = len_vec[rslot];
   assign rtrunc = trn_vec[rslot];

   a_r11_len_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
      len_we |-> (len_val != '0 && len_val <= LEN_W'(SLOT_BYTES)));

   a_r11_trunc_full_len: assert property (@(posedge clk) disable iff (!rst_n)
      (len_we && trunc_val) |-> (len_val == LEN_W'(SLOT_BYTES)));

endmodule

// File: rtl/eth_rx_slot_ring.sv
module eth_rx_slot_ring #(
   parameter int SLOTS      = 4,
   parameter int SLOT_BYTES = 64,
   parameter int FILTER_LAT = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              s_valid,
   input  logic [7:0]                        s_data,
   input  logic                              s_last,
   input  logic [47:0]                       station_mac,
   input  logic                              promisc,
   input  logic [$clog2(SLOT_BYTES)-1:0]     rd_addr,
   output logic [7:0]                        rd_data,
   output logic [$clog2(SLOT_BYTES+1)-1:0]   rd_len,
   output logic                              rd_trunc,
   input  logic                              pop,
   output logic                              avail
);

   localparam int SLOT_W     = $clog2(SLOTS);
   localparam int BYTE_W     = $clog2(SLOT_BYTES);
   localparam int IDX_W      = $clog2(SLOT_BYTES + 1);
   localparam int DECIDE_IDX = 5 + FILTER_LAT;
   localparam logic [IDX_W-1:0] DEC_AT = IDX_W'(DECIDE_IDX);
   localparam logic [IDX_W-1:0] SAT_AT = IDX_W'(SLOT_BYTES);

   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (SLOT_BYTES < 16 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_size
      $error("SLOT_BYTES must be a power of two, at least 16");
   end
   if (FILTER_LAT < 1 || DECIDE_IDX >= SLOT_BYTES) begin : g_bad_lat
      $error("FILTER_LAT must be at least 1 and the verdict byte must fit in a slot");
   end

   // Frame position; idle and post-frame value are both zero, so the
   // first frame after reset starts from the same state as any other.
   logic [IDX_W-1:0] idx_q;
   logic             acc_q;
   logic             beat, sof, verdict, commit, publish, drop, mem_we, ovf;
   logic [SLOT_W-1:0] wslot, pub_slot, first_slot, head;
   logic [IDX_W-1:0]  len_val;

   assign beat = s_valid;
   assign sof  = beat && idx_q == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         acc_q <= 1'b0;
      end else if (beat) begin
         if (s_last) begin
            idx_q <= '0;
            acc_q <= 1'b0;
         end else begin
            if (idx_q != SAT_AT)
               idx_q <= idx_q + 1'b1;
            if (commit)
               acc_q <= 1'b1;
         end
      end
   end

   rxr_dest_filter #(.IDX_W(IDX_W)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat    (beat),
      .idx     (idx_q),
      .data    (s_data),
      .station (station_mac),
      .promisc (promisc),
      .verdict (verdict)
   );

   assign commit  = beat && idx_q == DEC_AT && verdict && !drop;
   assign publish = beat && s_last && !drop && (acc_q || commit);
   // Bytes up to the verdict go out speculatively; later ones only if kept.
   assign mem_we  = beat && !drop && idx_q < SAT_AT && (idx_q <= DEC_AT || acc_q);
   assign ovf     = idx_q == SAT_AT;
   assign len_val = ovf ? SAT_AT : idx_q + 1'b1;

   rxr_ring_ctl #(.SLOTS(SLOTS)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof        (sof),
      .commit     (commit),
      .publish    (publish),
      .pop        (pop),
      .wslot      (wslot),
      .drop       (drop),
      .pub_slot   (pub_slot),
      .first_slot (first_slot)
   );

   assign avail = pub_slot != first_slot;
   assign head  = first_slot + 1'b1;

   rxr_byte_store #(.SLOTS(SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (mem_we),
      .wslot     (wslot),
      .widx      (idx_q[BYTE_W-1:0]),
      .wdata     (s_data),
      .len_we    (publish),
      .len_val   (len_val),
      .trunc_val (ovf),
      .rslot     (head),
      .raddr     (rd_addr),
      .rdata     (rd_data),
      .rlen      (rd_len),
      .rtrunc    (rd_trunc)
   );

   logic [SLOT_W-1:0] dist_w, dist_p;
   assign dist_w = wslot - first_slot;
   assign dist_p = pub_slot - first_slot;

   a_r4_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (dist_w != '0 && dist_w > dist_p));

   a_r8_idle_no_publish: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> ($stable(pub_slot) && $stable(rd_len) || $past(pop)));

   a_r13_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && s_last && idx_q < DEC_AT) |-> !publish);

endmodule

// File: tb/eth_rx_slot_ring_test.sv
`timescale 1ns/1ps
module eth_rx_slot_ring_test;

   localparam int NS = 4;
   localparam int SB = 32;
   localparam int IW = $clog2(SB + 1);
   localparam int AW = $clog2(SB);
   localparam logic [47:0] STN  = 48'h9A_BC_12_34_56_78;
   localparam logic [47:0] BC   = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MISS = 48'h9A_BC_12_34_56_79;

   logic clk = 1'b0, rst_n = 1'b0;
   logic s_valid = 1'b0, s_last = 1'b0, promisc = 1'b0, pop = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic [AW-1:0] rd_addr = '0;
   wire  [7:0] rd_data;
   wire  [IW-1:0] rd_len;
   wire  rd_trunc, avail;

   always #2 clk = ~clk;

   eth_rx_slot_ring #(.SLOTS(NS), .SLOT_BYTES(SB), .FILTER_LAT(2)) uut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
      .station_mac(STN), .promisc(promisc), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_len(rd_len), .rd_trunc(rd_trunc), .pop(pop), .avail(avail));

   int n_chk = 0, n_bad = 0;
   int q_len[$];
   int q_id[$];
   logic [47:0] q_dst[$];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [47:0] d, input int id, input int k);
      if (k < 6) return d[(5 - k) * 8 +: 8];
      return 8'((id * 29 + k * 7 + 3) & 255);
   endfunction

   // Drive one frame; gaps insert idle cycles carrying s_last=1 (R8).
   task automatic send(input logic [47:0] dst, input int len, input int id, input bit gaps);
      bit keep;
      int av0, l0;
      keep = (dst == STN || dst == BC || promisc) && len >= 8 && q_len.size() < NS - 1;
      av0 = avail;
      l0  = rd_len;
      for (int k = 0; k < len; k++) begin
         if (gaps && (k % 3) == 1) begin
            s_valid = 1'b0; s_last = 1'b1; s_data = 8'hA5;
            @(negedge clk);
         end
         if (k == len - 1 && len > 8) begin
            check("R7 avail before last byte", avail, av0);
            check("R7 rd_len before last byte", rd_len, l0);
         end
         s_valid = 1'b1;
         s_data  = pat(dst, id, k);
         s_last  = (k == len - 1);
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0; s_data = 8'h3C;
      if (keep) begin
         q_len.push_back(len); q_id.push_back(id); q_dst.push_back(dst);
      end
      check("R7 avail right after last byte", avail, q_len.size() > 0);
      s_last = 1'b1;
      @(negedge clk);
      s_last = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_head(input string req);
      int sl, mism;
      check({req, " avail"}, avail, 1);
      sl = q_len[0] > SB ? SB : q_len[0];
      check({req, " rd_len"}, rd_len, sl);
      check({req, " rd_trunc"}, rd_trunc, q_len[0] > SB);
      mism = 0;
      for (int k = 0; k < sl; k++) begin
         rd_addr = AW'(k);
         #0.2;
         if (rd_data != pat(q_dst[0], q_id[0], k)) mism++;
      end
      check({req, " byte mismatches"}, mism, 0);
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
      void'(q_len.pop_front()); void'(q_id.pop_front()); void'(q_dst.pop_front());
   endtask

   task automatic drain(input string req);
      while (q_len.size() > 0) check_head(req);
      check({req, " empty after drain"}, avail, 0);
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 avail after reset", avail, 0);
      check("R1 rd_len after reset", rd_len, 0);
      check("R1 rd_trunc after reset", rd_trunc, 0);

      // R9, R2: first frame after reset, unicast
      send(STN, 20, 1, 1'b0);
      drain("R9 R2 unicast first frame");

      // R3: broadcast
      send(BC, 12, 2, 1'b1);
      drain("R3 broadcast");

      // R6: kept frame then mismatch
      send(STN, 16, 3, 1'b0);
      send(MISS, 16, 4, 1'b0);
      drain("R6 no carried verdict");

      // R4: rejected frame between two kept frames
      send(STN, 24, 5, 1'b0);
      send(MISS, 30, 6, 1'b1);
      check("R4 avail after rejected frame", avail, 1);
      send(BC, 28, 7, 1'b0);
      drain("R4 neighbours intact");

      // R5: promiscuous
      promisc = 1'b1;
      send(MISS, 18, 8, 1'b0);
      promisc = 1'b0;
      drain("R5 promisc keeps");

      // R13: runt vs verdict-point frame
      send(STN, 7, 9, 1'b0);
      check("R13 runt not published", avail, 0);
      send(STN, 8, 10, 1'b0);
      drain("R13 eight-byte frame");

      // R12: idle pop ignored
      @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
      check("R12 idle pop keeps avail low", avail, 0);
      send(STN, 10, 11, 1'b0);
      send(BC, 11, 12, 1'b0);
      drain("R12 order after idle pop");

      // R10: overfill the ring
      for (int i = 0; i < NS + 1; i++) send(STN, 14 + i, 20 + i, 1'b0);
      check("R10 ring capped", q_len.size(), NS - 1);
      drain("R10 oldest frames intact");

      // R11: slot boundary
      send(STN, SB, 30, 1'b0);
      send(STN, SB + 1, 31, 1'b0);
      send(BC, SB + 8, 32, 1'b1);
      drain("R11 slot overflow");

      // Length sweep over all filter kinds, R8 gaps on odd lengths
      for (int len = 6; len <= SB + 8; len++) begin
         logic [47:0] d;
         case (len % 4)
            0: d = STN;
            1: d = BC;
            default: d = MISS;
         endcase
         promisc = (len % 4) == 3;
         send(d, len, 100 + len, (len % 2) == 1);
         promisc = 1'b0;
         if ((len % 3) == 0) drain("R8 R7 sweep");
      end
      drain("R8 R7 sweep final");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule